// File: doc/BRIEF.md
# Secure Real-Time Clock Register Block

This block keeps wall-clock time behind a small register port. The time is held in two counters. A 32-bit seconds count is paired with a 15-bit sub-second count, and the sub-second count advances once for each pulse on a tick input. An alarm compare checks the two counters against a two-word alarm value. Sticky status flags record completed writes, rejected writes, the alarm, an invalid-time condition and a security violation. Each flag can be routed to a single interrupt line.

Software never writes a register in one cycle. A write is captured, held busy for a fixed number of cycles, and only then applied, after which a completion flag is raised. A write that arrives while an earlier one is still pending is dropped and raises an error flag. This lets software pace its writes by polling status. The time counter also refuses to run until the seconds word has been written once since reset, so stale time is never advanced.

Top module: `rtc_secure_regs`

## Requirements
- R1: After reset, the block reads as follows. Status (word 5) reads 0x00000202, which is bit 9 write-next plus bit 1 invalid. Seconds (word 0) and fraction (word 1) read 0. Alarm seconds (word 2) reads 0xFFFFFFFF and alarm fraction (word 3) reads 0x00007FFF. Control (word 4) and interrupt enable (word 6) read 0, and irq_o is low.
- R2: An accepted write sets status bit 10 (busy) and clears bit 9 (write-next) from the cycle after acceptance, for exactly WAIT_CYCLES (4) cycles. The data is applied at the end of that period, and in the same cycle bit 10 clears while bit 9 and bit 8 (write complete) are set.
- R3: A write presented while busy is discarded: its target register keeps its value and status bit 7 (write error) is set in the next cycle.
- R4: A committed write to status clears each of bits 8, 7 and 4 where the data holds 1 and leaves each flag unchanged where it holds 0. Bits 10 and 9 cannot be written.
- R5: Status bit 1 (invalid) clears only when a single status write carries 1 in both bit 1 and bit 0.
- R6: Control bit 3 enables counting. While it is clear, both counters hold.
- R7: Until the seconds word has been written once after reset, the counters hold even with control bit 3 set.
- R8: While running, each tick increments the fraction count, which is 15 bits wide and held in bits 14:0 of word 1. When the count passes 0x7FFF it wraps to 0 and the seconds count increments.
- R9: Status bit 4 (alarm) is set when seconds equals alarm seconds and the fraction equals alarm fraction. No alarm is raised while alarm seconds is 0xFFFFFFFF.
- R10: irq_o is the OR of the status flags in bits 9, 8, 7 and 4, each gated by the interrupt-enable bit at the same position in word 6.
- R11: A pulse on viol_i sets status bit 0 (violation) and bit 1 (invalid). Writing 1 to bit 0 alone clears the violation but not the invalid flag.
- R12: Only the implemented bits are stored. Word 1 and word 3 keep bits 14:0, word 4 keeps bit 3, word 6 keeps bits 9, 8, 7 and 4, and word 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Sub-second advance pulse, one cycle wide |
| viol_i | input | 1 | Security violation event, one cycle wide |
| req_valid_i | input | 1 | Register request valid |
| req_write_i | input | 1 | Request is a write |
| req_addr_i | input | 3 | Word index of the register |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the word at req_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions rely on tick_i and viol_i being synchronous single-cycle pulses. They also rely on a request's address and data holding steady for the cycle in which valid is sampled, and on no tick arriving in the cycle where a counter write commits. The bench changes every input at a falling edge and samples outputs one time unit later. It keeps tick_i low throughout every write sequence, so each counter value it checks follows from a known count of ticks. It issues a second write inside the busy window only in the test that is meant to provoke the error flag.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned IDX_W  = 3;

  // Word index of each register; software depends on this order.
  typedef enum logic [IDX_W-1:0] {
    REG_SECS     = 3'd0,
    REG_FRAC     = 3'd1,
    REG_ALM_SECS = 3'd2,
    REG_ALM_FRAC = 3'd3,
    REG_CTRL     = 3'd4,
    REG_STAT     = 3'd5,
    REG_IEN      = 3'd6,
    REG_NONE     = 3'd7
  } reg_idx_e;

  localparam int unsigned CTRL_RUN_BIT = 3;

  localparam int unsigned ST_BUSY    = 10;
  localparam int unsigned ST_NEXT    = 9;
  localparam int unsigned ST_DONE    = 8;
  localparam int unsigned ST_ERR     = 7;
  localparam int unsigned ST_ALARM   = 4;
  localparam int unsigned ST_INVALID = 1;
  localparam int unsigned ST_VIOL    = 0;

  typedef struct packed {
    reg_idx_e            idx;
    logic [WORD_W-1:0]   data;
  } wr_cmd_t;

endpackage

// File: rtl/rtc_sec_wr_engine.sv
module rtc_sec_wr_engine
  import rtc_sec_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     req_i,
  input  reg_idx_e idx_i,
  input  logic [WORD_W-1:0] data_i,
  output logic     busy_o,
  output logic     commit_o,
  output logic     reject_o,
  output wr_cmd_t  cmd_o
);

  localparam int unsigned CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  wr_cmd_t          cmd_q, cmd_d;
  logic             accept;
  logic             commit;

  assign accept = req_i & ~busy_q;
  assign commit = busy_q & (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    cmd_d  = cmd_q;
    if (accept) begin
      busy_d     = 1'b1;
      cnt_d      = CNT_LAST;
      cmd_d.idx  = idx_i;
      cmd_d.data = data_i;
    end else if (commit) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q <= cmd_d;
    end
  end

  assign busy_o   = busy_q;
  assign commit_o = commit;
  assign reject_o = req_i & busy_q;
  assign cmd_o    = cmd_q;

  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);

  assert_commit_ends_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !busy_o);

  assert_cmd_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !commit_o) |=> $stable(cmd_o));

  assert_reject_needs_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> busy_o);

endmodule

// File: rtl/rtc_sec_timekeeper.sv
module rtc_sec_timekeeper
  import rtc_sec_pkg::*;
#(
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              commit_i,
  input  wr_cmd_t           cmd_i,
  output logic [WORD_W-1:0] secs_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [WORD_W-1:0] alm_secs_o,
  output logic [FRAC_W-1:0] alm_frac_o,
  output logic              run_en_o,
  output logic              alarm_hit_o
);

  localparam logic [FRAC_W-1:0] FRAC_MAX = '1;
  localparam logic [WORD_W-1:0] NO_ALARM = '1;

  logic [WORD_W-1:0] secs_q, secs_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic [WORD_W-1:0] alm_secs_q;
  logic [FRAC_W-1:0] alm_frac_q;
  logic              run_en_q;
  logic              secs_seen_q;

  logic wr_secs, wr_frac, wr_alm_secs, wr_alm_frac, wr_ctrl, wr_cnt;
  logic running, step, carry;

  assign wr_secs     = commit_i & (cmd_i.idx == REG_SECS);
  assign wr_frac     = commit_i & (cmd_i.idx == REG_FRAC);
  assign wr_alm_secs = commit_i & (cmd_i.idx == REG_ALM_SECS);
  assign wr_alm_frac = commit_i & (cmd_i.idx == REG_ALM_FRAC);
  assign wr_ctrl     = commit_i & (cmd_i.idx == REG_CTRL);
  assign wr_cnt      = wr_secs | wr_frac;

  assign running = run_en_q & secs_seen_q;
  assign step    = running & tick_i & ~wr_cnt;
  assign carry   = step & (frac_q == FRAC_MAX);

  // Counter next state: a committed write to either word owns the cycle.
  always_comb begin
    secs_d = secs_q;
    frac_d = frac_q;
    if (wr_secs) begin
      secs_d = cmd_i.data;
    end else if (wr_frac) begin
      frac_d = cmd_i.data[FRAC_W-1:0];
    end else if (step) begin
      frac_d = frac_q + 1'b1;
      if (carry) begin
        secs_d = secs_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secs_q <= '0;
      frac_q <= '0;
    end else begin
      secs_q <= secs_d;
      frac_q <= frac_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      secs_seen_q <= 1'b0;
    end else if (wr_secs) begin
      secs_seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_secs_q <= NO_ALARM;
    end else if (wr_alm_secs) begin
      alm_secs_q <= cmd_i.data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_frac_q <= FRAC_MAX;
    end else if (wr_alm_frac) begin
      alm_frac_q <= cmd_i.data[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_en_q <= cmd_i.data[CTRL_RUN_BIT];
    end
  end

  assign alarm_hit_o = (alm_secs_q != NO_ALARM) &&
                       (secs_q == alm_secs_q) && (frac_q == alm_frac_q);

  assign secs_o     = secs_q;
  assign frac_o     = frac_q;
  assign alm_secs_o = alm_secs_q;
  assign alm_frac_o = alm_frac_q;
  assign run_en_o   = run_en_q;

  assert_hold_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_q && !wr_cnt) |=> ($stable(secs_q) && $stable(frac_q)));

  assert_frozen_unwritten_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!secs_seen_q && !wr_cnt) |=> $stable(frac_q));

  assert_wrap_carry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && tick_i && !wr_cnt && frac_q == FRAC_MAX) |=>
      (frac_q == '0 && secs_q == $past(secs_q) + 1'b1));

endmodule

// File: rtl/rtc_sec_status_irq.sv
module rtc_sec_status_irq
  import rtc_sec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              commit_i,
  input  wr_cmd_t           cmd_i,
  input  logic              reject_i,
  input  logic              alarm_hit_i,
  input  logic              viol_i,
  output logic [WORD_W-1:0] status_o,
  output logic [WORD_W-1:0] ien_o,
  output logic              irq_o
);

  logic done_q, done_d;
  logic err_q, err_d;
  logic alarm_q, alarm_d;
  logic inval_q, inval_d;
  logic viol_q, viol_d;
  logic ien_next_q, ien_done_q, ien_err_q, ien_alarm_q;

  logic              wr_stat, wr_ien, clr_both, next_flag;
  logic [WORD_W-1:0] clr;

  assign wr_stat   = commit_i & (cmd_i.idx == REG_STAT);
  assign wr_ien    = commit_i & (cmd_i.idx == REG_IEN);
  assign clr       = wr_stat ? cmd_i.data : '0;
  assign clr_both  = clr[ST_INVALID] & clr[ST_VIOL];
  assign next_flag = ~busy_i;

  // Event sets take priority over a same-cycle clear, except that a status
  // write's own completion can be cleared by its own data.
  always_comb begin
    done_d  = (done_q | commit_i) & ~clr[ST_DONE];
    err_d   = (err_q & ~clr[ST_ERR]) | reject_i;
    alarm_d = (alarm_q & ~clr[ST_ALARM]) | alarm_hit_i;
    inval_d = (inval_q & ~clr_both) | viol_i;
    viol_d  = (viol_q & ~clr[ST_VIOL]) | viol_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      alarm_q <= 1'b0;
      inval_q <= 1'b1;
      viol_q  <= 1'b0;
    end else begin
      done_q  <= done_d;
      err_q   <= err_d;
      alarm_q <= alarm_d;
      inval_q <= inval_d;
      viol_q  <= viol_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_next_q  <= 1'b0;
      ien_done_q  <= 1'b0;
      ien_err_q   <= 1'b0;
      ien_alarm_q <= 1'b0;
    end else if (wr_ien) begin
      ien_next_q  <= cmd_i.data[ST_NEXT];
      ien_done_q  <= cmd_i.data[ST_DONE];
      ien_err_q   <= cmd_i.data[ST_ERR];
      ien_alarm_q <= cmd_i.data[ST_ALARM];
    end
  end

  always_comb begin
    status_o             = '0;
    status_o[ST_BUSY]    = busy_i;
    status_o[ST_NEXT]    = next_flag;
    status_o[ST_DONE]    = done_q;
    status_o[ST_ERR]     = err_q;
    status_o[ST_ALARM]   = alarm_q;
    status_o[ST_INVALID] = inval_q;
    status_o[ST_VIOL]    = viol_q;
  end

  always_comb begin
    ien_o           = '0;
    ien_o[ST_NEXT]  = ien_next_q;
    ien_o[ST_DONE]  = ien_done_q;
    ien_o[ST_ERR]   = ien_err_q;
    ien_o[ST_ALARM] = ien_alarm_q;
  end

  assign irq_o = (next_flag & ien_next_q) | (done_q & ien_done_q) |
                 (err_q & ien_err_q) | (alarm_q & ien_alarm_q);

  assert_err_on_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_i |=> err_q);

  assert_invalid_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(inval_q) |-> $past(commit_i && cmd_i.idx == REG_STAT &&
                             cmd_i.data[ST_INVALID] && cmd_i.data[ST_VIOL]));

  assert_alarm_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_q) |-> $past(alarm_hit_i));

  assert_viol_sets_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> (viol_q && inval_q));

endmodule

// File: rtl/rtc_secure_regs.sv
module rtc_secure_regs
  import rtc_sec_pkg::*;
#(
  parameter int unsigned FRAC_W      = 15,
  parameter int unsigned WAIT_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              viol_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [IDX_W-1:0]  req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int unsigned SYNC_N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_n = rst_sync_q[SYNC_N-1];

  reg_idx_e          req_idx;
  logic              wr_req;
  logic              busy, commit, reject;
  wr_cmd_t           cmd;
  logic [WORD_W-1:0] secs, alm_secs, status_word, ien_word;
  logic [FRAC_W-1:0] frac, alm_frac;
  logic              run_en, alarm_hit;

  assign req_idx = reg_idx_e'(req_addr_i);
  assign wr_req  = req_valid_i & req_write_i;

  rtc_sec_wr_engine #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_wr_engine (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .req_i    (wr_req),
    .idx_i    (req_idx),
    .data_i   (req_wdata_i),
    .busy_o   (busy),
    .commit_o (commit),
    .reject_o (reject),
    .cmd_o    (cmd)
  );

  rtc_sec_timekeeper #(
    .FRAC_W (FRAC_W)
  ) u_timekeeper (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .tick_i      (tick_i),
    .commit_i    (commit),
    .cmd_i       (cmd),
    .secs_o      (secs),
    .frac_o      (frac),
    .alm_secs_o  (alm_secs),
    .alm_frac_o  (alm_frac),
    .run_en_o    (run_en),
    .alarm_hit_o (alarm_hit)
  );

  rtc_sec_status_irq u_status_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .busy_i      (busy),
    .commit_i    (commit),
    .cmd_i       (cmd),
    .reject_i    (reject),
    .alarm_hit_i (alarm_hit),
    .viol_i      (viol_i),
    .status_o    (status_word),
    .ien_o       (ien_word),
    .irq_o       (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    unique case (req_idx)
      REG_SECS:     rdata_o = secs;
      REG_FRAC:     rdata_o = WORD_W'(frac);
      REG_ALM_SECS: rdata_o = alm_secs;
      REG_ALM_FRAC: rdata_o = WORD_W'(alm_frac);
      REG_CTRL:     rdata_o[CTRL_RUN_BIT] = run_en;
      REG_STAT:     rdata_o = status_word;
      REG_IEN:      rdata_o = ien_word;
      REG_NONE:     rdata_o = '0;
      default:      rdata_o = '0;
    endcase
  end

  assert_write_next_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    status_word[ST_NEXT] != status_word[ST_BUSY]);

endmodule

// File: tb/rtc_secure_regs_bench.sv
module rtc_secure_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WAIT       = 4;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        viol = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = 3'd0;
  logic [31:0] req_wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_secure_regs u_rtc_secure_regs (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .viol_i      (viol),
    .req_valid_i (req_valid),
    .req_write_i (req_write),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .rdata_o     (rdata),
    .irq_o       (irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    req_addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = 1'b1;
    req_addr  = a;
    req_wdata = d;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_write = 1'b0;
    repeat (WAIT) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(3'd5, v); chk("R1 status", v, 32'h0000_0202);
    rd(3'd0, v); chk("R1 seconds", v, 32'h0);
    rd(3'd1, v); chk("R1 fraction", v, 32'h0);
    rd(3'd2, v); chk("R1 alarm seconds", v, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R1 alarm fraction", v, 32'h0000_7FFF);
    rd(3'd4, v); chk("R1 control", v, 32'h0);
    rd(3'd6, v); chk("R1 irq enable", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_handshake;
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd4; req_wdata = 32'h8;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    rd(3'd5, v); chk("R2 busy after accept", v, 32'h0000_0402);
    for (int i = 1; i < WAIT; i++) begin
      @(negedge clk);
      rd(3'd5, v); chk("R2 busy held", v, 32'h0000_0402);
    end
    rd(3'd4, v); chk("R2 data not yet applied", v, 32'h0);
    @(negedge clk);
    rd(3'd5, v); chk("R2 complete", v, 32'h0000_0302);
    rd(3'd4, v); chk("R2 data applied", v, 32'h8);
  endtask

  task automatic t_freeze_and_count;
    logic [31:0] v;
    ticks(5);
    rd(3'd1, v); chk("R7 fraction frozen", v, 32'h0);
    wr(3'd0, 32'h100);
    ticks(5);
    rd(3'd1, v); chk("R7 fraction counts after seconds write", v, 32'h5);
    rd(3'd0, v); chk("R7 seconds kept", v, 32'h100);
    wr(3'd4, 32'h0);
    ticks(4);
    rd(3'd1, v); chk("R6 hold when disabled", v, 32'h5);
    wr(3'd4, 32'h8);
    ticks(2);
    rd(3'd1, v); chk("R6 resume", v, 32'h7);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(3'd1, 32'h7FFE);
    ticks(3);
    rd(3'd1, v); chk("R8 fraction after wrap", v, 32'h1);
    rd(3'd0, v); chk("R8 seconds carry", v, 32'h101);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 3'd2; req_wdata = 32'h55;
    @(posedge clk);
    @(negedge clk);
    req_addr = 3'd3; req_wdata = 32'h77;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    rd(3'd5, v); chk("R3 error flag", v & 32'h80, 32'h80);
    repeat (WAIT - 1) @(posedge clk);
    @(negedge clk);
    rd(3'd2, v); chk("R3 first write applied", v, 32'h55);
    rd(3'd3, v); chk("R3 second write dropped", v, 32'h7FFF);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(3'd5, 32'h0);
    rd(3'd5, v); chk("R4 zero keeps error", v & 32'h80, 32'h80);
    wr(3'd5, 32'h80);
    rd(3'd5, v); chk("R4 one clears error", v & 32'h80, 32'h0);
    wr(3'd5, 32'h100);
    rd(3'd5, v); chk("R4 clear complete", v, 32'h0000_0202);
    wr(3'd5, 32'h600);
    rd(3'd5, v); chk("R4 busy and next not writable", v, 32'h0000_0302);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R12 control stores bit 3", v, 32'h8);
    wr(3'd4, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R12 fraction width", v, 32'h7FFF);
    rd(3'd7, v); chk("R12 unused word", v, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v); chk("R12 enable bits", v, 32'h0000_0390);
    chk("R10 irq from write-next", {31'd0, irq}, 32'h1);
    wr(3'd6, 32'h0);
    chk("R10 irq masked", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_nonvalid;
    logic [31:0] v;
    wr(3'd5, 32'h2);
    rd(3'd5, v); chk("R5 bit 1 alone", v & 32'h3, 32'h2);
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R5 bit 0 alone", v & 32'h3, 32'h2);
    wr(3'd5, 32'h3);
    rd(3'd5, v); chk("R5 both bits", v & 32'h3, 32'h0);
    @(negedge clk);
    viol = 1'b1;
    @(negedge clk);
    viol = 1'b0;
    rd(3'd5, v); chk("R11 violation sets flags", v & 32'h3, 32'h3);
    wr(3'd5, 32'h1);
    rd(3'd5, v); chk("R11 violation cleared alone", v & 32'h3, 32'h2);
    wr(3'd5, 32'h3);
    rd(3'd5, v); chk("R11 both cleared", v & 32'h3, 32'h0);
  endtask

  task automatic t_alarm;
    logic [31:0] v;
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    rd(3'd5, v); chk("R9 all-ones disables alarm", v & 32'h10, 32'h0);
    wr(3'd3, 32'h3);
    wr(3'd0, 32'h200);
    wr(3'd2, 32'h200);
    wr(3'd6, 32'h10);
    rd(3'd5, v); chk("R9 no alarm before match", v & 32'h10, 32'h0);
    chk("R10 irq low before alarm", {31'd0, irq}, 32'h0);
    wr(3'd4, 32'h8);
    ticks(3);
    rd(3'd1, v); chk("R9 fraction at alarm", v, 32'h3);
    @(negedge clk);
    rd(3'd5, v); chk("R9 alarm flag", v & 32'h10, 32'h10);
    chk("R10 irq from alarm", {31'd0, irq}, 32'h1);
    ticks(1);
    wr(3'd5, 32'h10);
    rd(3'd5, v); chk("R4 alarm cleared", v & 32'h10, 32'h0);
    chk("R10 irq after clear", {31'd0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_handshake();
    t_freeze_and_count();
    t_wrap();
    t_reject();
    t_w1c();
    t_map();
    t_nonvalid();
    t_alarm();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule